// File: doc/BRIEF.md
# Interrupt Reason Register with Interval Clock

This block gathers the conditions that should stop a user program and keeps them in one register. A hardware interval clock also runs freely inside it. Event pulses arrive for typewriter attention, address-limit violation, stack violation, end of transfer and the OUT request. The clock-overflow reason comes from the block's own counter. A mode input says whether the processor runs in supervisor or user mode.

The supervisor reads the register with a one-cycle strobe. One cycle later a 48-bit word appears. It holds every pending reason and the upper bits of the clock. The read also clears every reason that it returned. The interrupt request is a level. In user mode any pending reason raises it. In supervisor mode only the escalated RESET reason raises it. RESET is set when the clock overflows a second time before the earlier overflow has been read.

The clock counts one tick every `TICK_DIV` cycles of the core clock, which is meant to give one tick every 16 µs. It wraps at 2^`CNT_W`. With the default width of 16 bits it wraps every 2^20 µs.

Top module: `irq_reason_unit`

## Requirements
- R1: The clock counter starts at zero after reset. It advances by one on every `TICK_DIV`-th core cycle, wraps from 2^`CNT_W`-1 to zero, and no read clears it.
- R2: When the clock wraps, the overflow reason is latched and appears at word bit 0.
- R3: A read strobe in cycle n loads `rd_data` at the end of cycle n. The word holds until the next strobe and is laid out as follows: bit 0 overflow; bits 1 up to `CNT_W`-1 (at most bit 15) the clock bits 1 upward as they stood before the strobe's edge; bit 23 typewriter; bit 24 limit violation; bit 25 stack violation; bit 26 end of transfer; bit 27 OUT; bit 29 RESET. All other bits are zero.
- R4: A read clears every reason it reported. A second read with no new events between the two returns no reasons.
- R5: An event that arrives in the same cycle as a read strobe is absent from that word and remains pending for the next read.
- R6: A clock wrap while the overflow reason is still pending, with no read in that cycle, sets RESET.
- R7: A stack-violation pulse is ignored while `supervisor` is 1.
- R8: While `supervisor` is 0, `irq` is 1 whenever any reason is pending.
- R9: While `supervisor` is 1, `irq` is 1 exactly when RESET is pending.
- R10: After reset, `rd_data` is zero, no reason is pending and `irq` is 0.
- R11: If reasons are pending when `supervisor` falls to 0, `irq` rises in that same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| supervisor | input | 1 | 1 = supervisor mode, 0 = user mode |
| ev_typewriter | input | 1 | Typewriter attention pulse |
| ev_limit | input | 1 | Address-limit violation pulse |
| ev_stack | input | 1 | Stack-violation pulse |
| ev_xfer_end | input | 1 | End-of-transfer pulse |
| ev_out | input | 1 | OUT request pulse |
| rd_strobe | input | 1 | Read and clear the reason register |
| rd_data | output | 48 | Last word read |
| irq | output | 1 | Level interrupt request |

## Verification
The reason latches are hidden state. A wrong latch shows up first at `irq` in user mode, in the same cycle. Otherwise it shows up in the next word read, one cycle after the strobe. A clock that drifts shows as a wrong clock field in the next read, and the error grows with every later read. A missed or extra overflow shows up a full wrap period later as a missing or spurious RESET. For that reason the bench leaves the register unread across two wraps.

// File: rtl/irr_pkg.sv
package irr_pkg;

    localparam int WORD_W  = 48;
    localparam int B_OVF   = 0;
    localparam int B_TYPE  = 23;
    localparam int B_LIMIT = 24;
    localparam int B_STACK = 25;
    localparam int B_XFER  = 26;
    localparam int B_OUT   = 27;
    localparam int B_RESET = 29;

    typedef struct packed {
        logic hard_reset;
        logic out_cmd;
        logic xfer_end;
        logic stack_viol;
        logic limit_viol;
        logic typewriter;
        logic clk_ovf;
    } reasons_t;

    function automatic logic [WORD_W-1:0] pack_word(reasons_t r, logic [14:0] clk_hi);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[B_OVF]   = r.clk_ovf;
        w[15:1]    = clk_hi;
        w[B_TYPE]  = r.typewriter;
        w[B_LIMIT] = r.limit_viol;
        w[B_STACK] = r.stack_viol;
        w[B_XFER]  = r.xfer_end;
        w[B_OUT]   = r.out_cmd;
        w[B_RESET] = r.hard_reset;
        return w;
    endfunction

endpackage

// File: rtl/irr_prescaler.sv
module irr_prescaler #(
    parameter int TICK_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_count
            localparam int DW = $clog2(TICK_DIV);
            localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst)               div_q <= '0;
                else if (div_q == LAST) div_q <= '0;
                else                   div_q <= div_q + 1'b1;
            end
            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/irr_interval_clock.sv
module irr_interval_clock #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end
    assign wrap = tick & (&cnt);
endmodule

// File: rtl/irr_reason_latch.sv
module irr_reason_latch
    import irr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     supervisor,
    input  logic     rd_strobe,
    input  reasons_t events,
    output reasons_t pending
);
    reasons_t set_v;
    reasons_t next_v;

    always_comb begin
        set_v            = events;
        set_v.stack_viol = events.stack_viol & ~supervisor;
        set_v.hard_reset = events.clk_ovf & pending.clk_ovf & ~rd_strobe;
        if (rd_strobe) next_v = set_v;
        else           next_v = pending | set_v;
    end

    always_ff @(posedge clk) begin
        if (rst) pending <= '0;
        else     pending <= next_v;
    end
endmodule

// File: rtl/irq_reason_unit.sv
module irq_reason_unit
    import irr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        supervisor,
    input  logic        ev_typewriter,
    input  logic        ev_limit,
    input  logic        ev_stack,
    input  logic        ev_xfer_end,
    input  logic        ev_out,
    input  logic        rd_strobe,
    output logic [47:0] rd_data,
    output logic        irq
);
    localparam int HI_W = (CNT_W - 1 < 15) ? CNT_W - 1 : 15;

    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    reasons_t         events;
    reasons_t         pending;
    logic [14:0]      clk_hi;

    irr_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk(clk), .rst(rst), .tick(tick)
    );

    irr_interval_clock #(.CNT_W(CNT_W)) u_clk (
        .clk(clk), .rst(rst), .tick(tick), .cnt(cnt), .wrap(wrap)
    );

    always_comb begin
        events            = '0;
        events.clk_ovf    = wrap;
        events.typewriter = ev_typewriter;
        events.limit_viol = ev_limit;
        events.stack_viol = ev_stack;
        events.xfer_end   = ev_xfer_end;
        events.out_cmd    = ev_out;
    end

    irr_reason_latch u_lat (
        .clk(clk), .rst(rst), .supervisor(supervisor), .rd_strobe(rd_strobe),
        .events(events), .pending(pending)
    );

    assign clk_hi = 15'(cnt[CNT_W-1 -: HI_W]);

    always_ff @(posedge clk) begin
        if (rst)            rd_data <= '0;
        else if (rd_strobe) rd_data <= pack_word(pending, clk_hi);
    end

    assign irq = pending.hard_reset | (~supervisor & (|pending));
endmodule

// File: rtl/irr_checker.sv
module irr_checker
    import irr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             supervisor,
    input logic             rd_strobe,
    input logic             ev_any,
    input logic             tick,
    input logic             wrap,
    input logic [CNT_W-1:0] cnt,
    input reasons_t         pending,
    input logic [47:0]      rd_data,
    input logic             irq
);
    localparam logic [47:0] USED = 48'h0000_2F80_FFFF;

    p_clock_step_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> cnt == CNT_W'($past(cnt) + 1'b1));

    p_wrap_latch_r2: assert property (@(posedge clk) disable iff (rst)
        wrap |=> pending.clk_ovf);

    p_word_clean_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~USED) == '0);

    p_clear_on_read_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !ev_any && !wrap) |=> pending == '0);

    p_double_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (wrap && pending.clk_ovf && !rd_strobe) |=> pending.hard_reset);

    p_stack_masked_r7: assert property (@(posedge clk) disable iff (rst)
        (supervisor && !pending.stack_viol) |=> !pending.stack_viol);

    p_irq_user_r8: assert property (@(posedge clk) disable iff (rst)
        (!supervisor && pending != '0) |-> irq);

    p_irq_super_r9: assert property (@(posedge clk) disable iff (rst)
        supervisor |-> (irq == pending.hard_reset));
endmodule

bind irq_reason_unit irr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .supervisor(supervisor), .rd_strobe(rd_strobe),
    .ev_any(ev_typewriter | ev_limit | ev_stack | ev_xfer_end | ev_out),
    .tick(tick), .wrap(wrap), .cnt(cnt), .pending(pending),
    .rd_data(rd_data), .irq(irq)
);

// File: tb/irq_reason_unit_tb.sv
module irq_reason_unit_tb;
    localparam int CNT_W    = 8;
    localparam int TICK_DIV = 2;
    localparam int PERIOD   = TICK_DIV << CNT_W;

    logic clk = 0;
    logic rst = 1;
    logic supervisor = 1;
    logic ev_typewriter = 0, ev_limit = 0, ev_stack = 0, ev_xfer_end = 0, ev_out = 0;
    logic rd_strobe = 0;
    logic [47:0] rd_data;
    logic irq;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit live = 0;

    always #5 clk = ~clk;

    irq_reason_unit #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_dut (
        .clk(clk), .rst(rst), .supervisor(supervisor),
        .ev_typewriter(ev_typewriter), .ev_limit(ev_limit), .ev_stack(ev_stack),
        .ev_xfer_end(ev_xfer_end), .ev_out(ev_out),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .irq(irq)
    );

    // reference model
    int m_div, m_cnt;
    bit m_ovf, m_typ, m_lim, m_stk, m_xfr, m_out, m_rst;
    logic [47:0] m_word;

    function automatic logic [47:0] build();
        logic [47:0] w = '0;
        w[0]  = m_ovf;
        for (int i = 1; i < CNT_W && i <= 15; i++) w[i] = (m_cnt >> i) & 1;
        w[23] = m_typ; w[24] = m_lim; w[25] = m_stk;
        w[26] = m_xfr; w[27] = m_out; w[29] = m_rst;
        return w;
    endfunction

    always @(posedge clk) begin
        bit tk, wr, old_ovf;
        if (rst) begin
            m_div = 0; m_cnt = 0; m_word = '0;
            {m_ovf, m_typ, m_lim, m_stk, m_xfr, m_out, m_rst} = '0;
        end else begin
            tk = (m_div == TICK_DIV - 1);
            wr = tk && (m_cnt == (1 << CNT_W) - 1);
            old_ovf = m_ovf;
            if (rd_strobe) begin
                m_word = build();
                {m_ovf, m_typ, m_lim, m_stk, m_xfr, m_out, m_rst} = '0;
            end
            if (wr) m_ovf = 1;
            if (ev_typewriter) m_typ = 1;
            if (ev_limit) m_lim = 1;
            if (ev_stack && !supervisor) m_stk = 1;
            if (ev_xfer_end) m_xfr = 1;
            if (ev_out) m_out = 1;
            if (wr && old_ovf && !rd_strobe) m_rst = 1;
            m_div = tk ? 0 : m_div + 1;
            if (tk) m_cnt = (m_cnt + 1) % (1 << CNT_W);
        end
    end

    task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit exp_irq();
        bit any = m_ovf | m_typ | m_lim | m_stk | m_xfr | m_out | m_rst;
        return m_rst | (!supervisor && any);
    endfunction

    // per-cycle comparison, away from both edges
    always @(posedge clk) begin
        #2;
        if (live) begin
            chk("R3 word", rd_data, m_word);
            chk(supervisor ? "R9 irq" : "R8 irq", 48'(irq), 48'(exp_irq()));
        end
    end

    task automatic do_read();
        @(negedge clk) rd_strobe = 1;
        @(negedge clk) rd_strobe = 0;
    endtask

    task automatic pulse_typ_with_read();
        @(negedge clk) begin rd_strobe = 1; ev_typewriter = 1; end
        @(negedge clk) begin rd_strobe = 0; ev_typewriter = 0; end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 word", rd_data, '0);
        chk("R10 irq", 48'(irq), 48'(0));
        rst = 0;
        live = 1;
        // R1: clock field after a known number of cycles
        repeat (20) @(negedge clk);
        do_read();
        chk("R1 clock", 48'(rd_data[CNT_W-1:1]), 48'(((21 / TICK_DIV) % (1 << CNT_W)) >> 1));
        // R7: stack ignored in supervisor
        @(negedge clk) ev_stack = 1;
        @(negedge clk) ev_stack = 0;
        do_read();
        chk("R7 stack", 48'(rd_data[25]), 48'(0));
        // R5: event with read survives
        pulse_typ_with_read();
        chk("R5 same word", 48'(rd_data[23]), 48'(0));
        do_read();
        chk("R5 next word", 48'(rd_data[23]), 48'(1));
        do_read();
        chk("R4 cleared", rd_data & ~48'hFFFF, '0);
        // R9 / R11 / R8
        @(negedge clk) ev_limit = 1;
        @(negedge clk) ev_limit = 0;
        chk("R9 masked", 48'(irq), 48'(0));
        supervisor = 0;
        #1 chk("R11 immediate", 48'(irq), 48'(1));
        @(negedge clk) chk("R8 held", 48'(irq), 48'(1));
        do_read();
        chk("R8 cleared", 48'(irq), 48'(0));
        // R2 / R6: leave unread across wraps in supervisor
        supervisor = 1;
        repeat (PERIOD + 4) @(negedge clk);
        chk("R2 no reset yet", 48'(irq), 48'(0));
        do_read();
        chk("R2 ovf bit", 48'(rd_data[0]), 48'(1));
        repeat (2 * PERIOD + 4) @(negedge clk);
        chk("R6 irq super", 48'(irq), 48'(1));
        do_read();
        chk("R6 reset bit", 48'(rd_data[29]), 48'(1));
        chk("R1 wrap", 48'(rd_data[0]), 48'(1));
        // mixed traffic against the model
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            supervisor    = ($urandom_range(0, 3) != 0);
            ev_typewriter = ($urandom_range(0, 15) == 0);
            ev_limit      = ($urandom_range(0, 15) == 0);
            ev_stack      = ($urandom_range(0, 7) == 0);
            ev_xfer_end   = ($urandom_range(0, 15) == 0);
            ev_out        = ($urandom_range(0, 15) == 0);
            rd_strobe     = ($urandom_range(0, 9) == 0);
        end
        @(negedge clk);
        {ev_typewriter, ev_limit, ev_stack, ev_xfer_end, ev_out, rd_strobe} = '0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule